// File: doc/BRIEF.md
# Receive Queue Engine

This block keeps the receive side of a network controller supplied with buffers. It manages two rings in system memory. Software fills the descriptor ring with free buffers, and the block writes one status entry per frame into the status ring. Software passes ownership of entries to the block by writing a count into one of two enqueue registers, one per ring. The block keeps a separate credit count for each ring.

When the receive MAC reports a finished frame, the block checks that both rings have credit. It reads the next descriptor (buffer address and buffer index) and announces the buffer address on a one-cycle output. It then writes the two-word status entry, advances both ring pointers and raises the receive interrupt. A frame that cannot be taken is dropped. The loss is reported through the overrun flag of the next status entry that is written.

The controller is a single state machine with these states:
- ST_IDLE: waits for a frame.
- ST_FETCH_ADDR: reads descriptor word 0.
- ST_FETCH_INDEX: reads descriptor word 1.
- ST_REPORT: announces the buffer.
- ST_WRITE_W1: writes status word 1.
- ST_WRITE_W0: writes status word 0.
- ST_ADVANCE: moves the pointers, takes one credit from each ring and sets the interrupt.

The transitions are:
- ST_IDLE goes to ST_FETCH_ADDR when a frame is accepted.
- Each memory state moves on only when the memory grants the access.
- ST_REPORT always goes to ST_WRITE_W1.
- ST_ADVANCE always returns to ST_IDLE.

Top module: `rxq_engine`

## Requirements
- R1: After reset both credit counts read 0, the interrupt status reads 0, and `irq`, `buf_valid` and `mem_req` are low.
- R2: A write to the descriptor enqueue register (0x1C) adds the written value to the descriptor credit, readable at 0x20. A write to the status enqueue register (0x30) adds to the status credit, readable at 0x34. Each write affects only its own ring.
- R3: A frame offered on `fd_valid` is dropped when enable is set and any of these holds: either credit is zero, or the block is not idle (`fd_ready` low). A dropped frame causes no memory access. The next status entry written then has bit 20 (overrun) and bit 21 (error) set and bit 30 clear.
- R4: For an accepted frame the block reads the descriptor word at the descriptor current address, then the word at that address + 4. It then pulses `buf_valid` for one cycle with `buf_addr` equal to descriptor word 0.
- R5: Status word 1 is written at the status current address + 4. It holds bit 31 = 1, bits 30:16 = descriptor word 1 bits 30:16 (buffer index), and bits 15:0 = frame length.
- R6: Status word 0 is written at the status current address. Its bits are:
  - bit 31 = 1
  - bit 30 = no error
  - bits 29 and 28 = 1
  - bit 21 = any error
  - bit 20 = overrun
  - bit 19 = framing error (`fd_flags[2]`)
  - bit 18 = runt (`fd_flags[1]`)
  - bit 17 = oversize
  - bit 16 = CRC error (`fd_flags[0]`)
  - bit 15 = CRC included (`fd_flags[3]`)
  - all other bits 0
- R7: A frame whose length exceeds bits 15:0 of the maximum-length register (0x0C) is flagged as oversize (bit 17 and bit 21).
- R8: Status word 1 is always written before status word 0 of the same entry.
- R9: After each write-back both current addresses advance by 8, and each wraps to its base when it reaches base + length. Both credits drop by one.
- R10: Each write-back sets interrupt status bit 2 (register 0x08). Reading 0x08 clears it. `irq` equals status bit 2 AND enable bit 2 of register 0x04.
- R11: While `mem_gnt` is low, the block holds `mem_req`, `mem_we` and `mem_addr` unchanged.
- R12: With control bit 0 (register 0x00) clear, offered frames are ignored: no memory access, and no overrun is recorded.

Register map (byte offsets):

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | interrupt enable |
| 0x08 | interrupt status |
| 0x0C | maximum length |
| 0x10 | descriptor base |
| 0x14 | descriptor length |
| 0x18 | descriptor current |
| 0x1C | descriptor enqueue |
| 0x20 | descriptor credit |
| 0x24 | status base |
| 0x28 | status length |
| 0x2C | status current |
| 0x30 | status enqueue |
| 0x34 | status credit |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt status on 0x08) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the grant cycle |
| mem_gnt | input | 1 | Access completes in this cycle |
| fd_valid | input | 1 | Frame finished |
| fd_len | input | 16 | Frame length in bytes |
| fd_flags | input | 4 | [0] CRC error, [1] runt, [2] framing error, [3] CRC included |
| fd_ready | output | 1 | Engine idle and enabled |
| buf_valid | output | 1 | One-cycle pulse: buffer chosen for the frame |
| buf_addr | output | 32 | Address of the chosen buffer |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest condition to reach is the overrun path. A frame must arrive while one ring has credit and the other has none, or while the engine is still busy with the previous frame. The evidence only appears later, in the next entry that is written.

The stimulus reaches this condition in four steps:
- It exhausts both rings.
- It refills only the descriptor ring and offers a frame.
- It refills the status ring.
- It offers a second frame one cycle after an accepted one, so that the second frame lands in ST_FETCH_ADDR.

The following entries must then carry the overrun bits. Memory grant stalls are also injected during one frame, and the wrap of both rings is checked after the fourth entry.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_ADDR,
        ST_FETCH_INDEX,
        ST_REPORT,
        ST_WRITE_W1,
        ST_WRITE_W0,
        ST_ADVANCE
    } rxq_state_e;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_IEN    = 8'h04;
    localparam logic [7:0] OFF_ISTAT  = 8'h08;
    localparam logic [7:0] OFF_MAXLEN = 8'h0C;
    localparam logic [7:0] OFF_DRING  = 8'h10;
    localparam logic [7:0] OFF_SRING  = 8'h24;
    // per-ring sub-offsets: base, length, current, enqueue, credit
    localparam logic [7:0] SUB_BASE = 8'h00;
    localparam logic [7:0] SUB_LEN  = 8'h04;
    localparam logic [7:0] SUB_CUR  = 8'h08;
    localparam logic [7:0] SUB_ENQ  = 8'h0C;
    localparam logic [7:0] SUB_CRED = 8'h10;

    localparam int RX_IRQ_BIT = 2;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int AW          = 32,
    parameter int CW          = 16,
    parameter int ENTRY_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_base,
    input  logic          wr_len,
    input  logic          wr_cur,
    input  logic          wr_enq,
    input  logic [AW-1:0] wdata,
    input  logic          advance,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] len_o,
    output logic [AW-1:0] cur_o,
    output logic [CW-1:0] credit_o
);
    localparam logic [AW-1:0] STEP = AW'(ENTRY_BYTES);

    logic [AW-1:0] base_q, len_q, cur_q, cur_step;
    logic [CW-1:0] credit_q, add_v, sub_v;

    assign cur_step = cur_q + STEP;
    assign add_v    = wr_enq  ? wdata[CW-1:0] : '0;
    assign sub_v    = advance ? CW'(1)        : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            len_q    <= '0;
            cur_q    <= '0;
            credit_q <= '0;
        end else begin
            if (wr_base) base_q <= wdata;
            if (wr_len)  len_q  <= wdata;
            if (wr_cur)
                cur_q <= wdata;
            else if (advance)
                cur_q <= (cur_step >= base_q + len_q) ? base_q : cur_step;
            credit_q <= credit_q + add_v - sub_v;
        end
    end

    assign base_o   = base_q;
    assign len_o    = len_q;
    assign cur_o    = cur_q;
    assign credit_o = credit_q;
endmodule

// File: rtl/rxq_fsm.sv
module rxq_fsm
    import rxq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fd_valid,
    input  logic [LEN_W-1:0] fd_len,
    input  logic [3:0]       fd_flags,
    input  logic [LEN_W-1:0] max_len,
    input  logic [AW-1:0]    desc_cur,
    input  logic [AW-1:0]    stat_cur,
    input  logic [CW-1:0]    desc_credit,
    input  logic [CW-1:0]    stat_credit,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_gnt,
    output logic             fd_ready,
    output logic             buf_valid,
    output logic [AW-1:0]    buf_addr,
    output logic             advance,
    output logic             irq_set
);
    localparam int IDX_W = 15;
    localparam logic [AW-1:0] W1_OFF = AW'(4);

    rxq_state_e state_q, state_d;

    logic             accept, drop, ovr_pend_q;
    logic [LEN_W-1:0] len_q;
    logic [3:0]       flg_q;
    logic             ovr_q, big_q, any_err;
    logic [AW-1:0]    baddr_q;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      word0, word1;

    assign accept = fd_valid && enable && (state_q == ST_IDLE)
                    && (desc_credit != '0) && (stat_credit != '0);
    assign drop   = fd_valid && enable && !accept;

    assign any_err = ovr_q | big_q | flg_q[2] | flg_q[1] | flg_q[0];
    assign word0 = {1'b1, !any_err, 1'b1, 1'b1, 6'b0, any_err, ovr_q,
                    flg_q[2], flg_q[1], big_q, flg_q[0], flg_q[3], 15'b0};
    assign word1 = {1'b1, idx_q, 16'(len_q)};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (accept)  state_d = ST_FETCH_ADDR;
            ST_FETCH_ADDR:  if (mem_gnt) state_d = ST_FETCH_INDEX;
            ST_FETCH_INDEX: if (mem_gnt) state_d = ST_REPORT;
            ST_REPORT:                   state_d = ST_WRITE_W1;
            ST_WRITE_W1:    if (mem_gnt) state_d = ST_WRITE_W0;
            ST_WRITE_W0:    if (mem_gnt) state_d = ST_ADVANCE;
            ST_ADVANCE:                  state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        buf_valid = 1'b0;
        advance   = 1'b0;
        irq_set   = 1'b0;
        fd_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE:        fd_ready = enable;
            ST_FETCH_ADDR:  begin mem_req = 1'b1; mem_addr = desc_cur; end
            ST_FETCH_INDEX: begin mem_req = 1'b1; mem_addr = desc_cur + W1_OFF; end
            ST_REPORT:      buf_valid = 1'b1;
            ST_WRITE_W1:    begin mem_req = 1'b1; mem_we = 1'b1;
                                  mem_addr = stat_cur + W1_OFF; mem_wdata = word1; end
            ST_WRITE_W0:    begin mem_req = 1'b1; mem_we = 1'b1;
                                  mem_addr = stat_cur; mem_wdata = word0; end
            ST_ADVANCE:     begin advance = 1'b1; irq_set = 1'b1; end
            default:        ;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_pend_q <= 1'b0;
            len_q      <= '0;
            flg_q      <= '0;
            ovr_q      <= 1'b0;
            big_q      <= 1'b0;
            baddr_q    <= '0;
            idx_q      <= '0;
        end else begin
            if (accept) begin
                len_q      <= fd_len;
                flg_q      <= fd_flags;
                ovr_q      <= ovr_pend_q;
                big_q      <= fd_len > max_len;
                ovr_pend_q <= 1'b0;
            end else if (drop) begin
                ovr_pend_q <= 1'b1;
            end
            if (state_q == ST_FETCH_ADDR && mem_gnt)  baddr_q <= mem_rdata;
            if (state_q == ST_FETCH_INDEX && mem_gnt) idx_q   <= mem_rdata[30:16];
        end
    end

    assign buf_addr = baddr_q;
endmodule

// File: rtl/rxq_engine.sv
module rxq_engine
    import rxq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int LEN_W = 16,
    parameter int MAX_FRAME = 2044
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_gnt,
    input  logic             fd_valid,
    input  logic [LEN_W-1:0] fd_len,
    input  logic [3:0]       fd_flags,
    output logic             fd_ready,
    output logic             buf_valid,
    output logic [AW-1:0]    buf_addr,
    output logic             irq
);
    localparam int NRING = 2;
    localparam logic [31:0] MAXLEN_RST = {16'(MAX_FRAME), 16'(MAX_FRAME)};

    logic          ctrl_en;
    logic [2:0]    ien_q;
    logic          istat_q;
    logic [31:0]   maxlen_q;
    logic          fsm_advance, fsm_irq_set;
    logic [AW-1:0] ring_base [NRING];
    logic [AW-1:0] ring_len  [NRING];
    logic [AW-1:0] ring_cur  [NRING];
    logic [CW-1:0] ring_cred [NRING];

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        localparam logic [7:0] OFF = (g == 0) ? OFF_DRING : OFF_SRING;
        rxq_ring #(.AW(AW), .CW(CW), .ENTRY_BYTES(8)) ring_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_base  (reg_wr && reg_addr == OFF + SUB_BASE),
            .wr_len   (reg_wr && reg_addr == OFF + SUB_LEN),
            .wr_cur   (reg_wr && reg_addr == OFF + SUB_CUR),
            .wr_enq   (reg_wr && reg_addr == OFF + SUB_ENQ),
            .wdata    (AW'(reg_wdata)),
            .advance  (fsm_advance),
            .base_o   (ring_base[g]),
            .len_o    (ring_len[g]),
            .cur_o    (ring_cur[g]),
            .credit_o (ring_cred[g])
        );
    end

    rxq_fsm #(.AW(AW), .CW(CW), .LEN_W(LEN_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctrl_en),
        .fd_valid    (fd_valid),
        .fd_len      (fd_len),
        .fd_flags    (fd_flags),
        .max_len     (LEN_W'(maxlen_q[15:0])),
        .desc_cur    (ring_cur[0]),
        .stat_cur    (ring_cur[1]),
        .desc_credit (ring_cred[0]),
        .stat_credit (ring_cred[1]),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_gnt     (mem_gnt),
        .fd_ready    (fd_ready),
        .buf_valid   (buf_valid),
        .buf_addr    (buf_addr),
        .advance     (fsm_advance),
        .irq_set     (fsm_irq_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ien_q    <= '0;
            istat_q  <= 1'b0;
            maxlen_q <= MAXLEN_RST;
        end else begin
            if (reg_wr && reg_addr == OFF_CTRL)   ctrl_en  <= reg_wdata[0];
            if (reg_wr && reg_addr == OFF_IEN)    ien_q    <= reg_wdata[2:0];
            if (reg_wr && reg_addr == OFF_MAXLEN) maxlen_q <= reg_wdata;
            if (fsm_irq_set)                          istat_q <= 1'b1;
            else if (reg_rd && reg_addr == OFF_ISTAT) istat_q <= 1'b0;
        end
    end

    assign irq = istat_q && ien_q[RX_IRQ_BIT];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CTRL:              reg_rdata = {31'b0, ctrl_en};
            OFF_IEN:               reg_rdata = {29'b0, ien_q};
            OFF_ISTAT:             reg_rdata = {29'b0, istat_q, 2'b0};
            OFF_MAXLEN:            reg_rdata = maxlen_q;
            OFF_DRING + SUB_BASE:  reg_rdata = 32'(ring_base[0]);
            OFF_DRING + SUB_LEN:   reg_rdata = 32'(ring_len[0]);
            OFF_DRING + SUB_CUR:   reg_rdata = 32'(ring_cur[0]);
            OFF_DRING + SUB_CRED:  reg_rdata = 32'(ring_cred[0]);
            OFF_SRING + SUB_BASE:  reg_rdata = 32'(ring_base[1]);
            OFF_SRING + SUB_LEN:   reg_rdata = 32'(ring_len[1]);
            OFF_SRING + SUB_CUR:   reg_rdata = 32'(ring_cur[1]);
            OFF_SRING + SUB_CRED:  reg_rdata = 32'(ring_cred[1]);
            default:               reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxq_engine_chk.sv
module rxq_engine_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          buf_valid,
    input logic          advance,
    input logic [CW-1:0] desc_credit,
    input logic [CW-1:0] stat_credit,
    input logic [AW-1:0] stat_cur,
    input logic          reg_rd,
    input logic [7:0]    reg_addr,
    input logic          irq_set,
    input logic          irq
);
    logic [AW-1:0] last_wr_q;
    logic          last_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr_q <= '0;
            last_ok_q <= 1'b0;
        end else if (mem_req && mem_we && mem_gnt) begin
            last_wr_q <= mem_addr;
            last_ok_q <= 1'b1;
        end
    end

    assert_credit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (desc_credit != '0) && (stat_credit != '0));

    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |=> !buf_valid);

    assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt && mem_addr == stat_cur)
        |-> last_ok_q && last_wr_q == stat_cur + AW'(4));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h08 && !irq_set) |=> !irq);
endmodule

bind rxq_engine rxq_engine_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_gnt     (mem_gnt),
    .mem_addr    (mem_addr),
    .buf_valid   (buf_valid),
    .advance     (fsm_advance),
    .desc_credit (ring_cred[0]),
    .stat_credit (ring_cred[1]),
    .stat_cur    (ring_cur[1]),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .irq_set     (fsm_irq_set),
    .irq         (irq)
);

// File: tb/rxq_engine_tb_top.sv
`timescale 1ns/1ps
module rxq_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        fd_valid = 1'b0;
    logic [15:0] fd_len = '0;
    logic [3:0]  fd_flags = '0;
    logic        fd_ready, buf_valid, irq;
    logic [31:0] buf_addr;

    always #4 clk = ~clk;

    rxq_engine dut_i (.*);

    // memory model: 256 words, byte address bits 9:2
    logic [31:0] mem [256];
    logic        stall_en = 1'b0, gnt_tog = 1'b0;
    logic        tb_wr = 1'b0;
    logic [31:0] tb_wa = '0, tb_wd = '0;
    int          wr_count = 0, ord_checks = 0, ord_fails = 0;
    logic [31:0] last_wr = '0;

    assign mem_gnt   = stall_en ? gnt_tog : 1'b1;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        gnt_tog <= ~gnt_tog;
        if (tb_wr) mem[tb_wa[9:2]] <= tb_wd;
        if (mem_req && mem_we && mem_gnt) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wr_count <= wr_count + 1;
            if (mem_addr[2] == 1'b0) begin
                ord_checks <= ord_checks + 1;
                if (last_wr != mem_addr + 4) begin
                    ord_fails <= ord_fails + 1;
                    $display("FAIL R8 order: last write %h, expected %h", last_wr, mem_addr + 4);
                end
            end
            last_wr <= mem_addr;
        end
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); tb_wr = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk); tb_wr = 1'b0;
    endtask

    // offer a frame, wait until the engine is idle again; report buffer seen
    task automatic frame(input logic [15:0] len, input logic [3:0] flg,
                         output bit seen, output logic [31:0] ba);
        seen = 1'b0; ba = '0;
        @(negedge clk); fd_valid = 1'b1; fd_len = len; fd_flags = flg;
        @(negedge clk); fd_valid = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (buf_valid) begin seen = 1'b1; ba = buf_addr; end
            if (fd_ready) break;
            @(negedge clk);
        end
    endtask

    localparam logic [15:0] V_LEN [4] = '{16'd64, 16'd100, 16'd60, 16'd3000};
    localparam logic [3:0]  V_FLG [4] = '{4'b0000, 4'b1000, 4'b0011, 4'b0000};
    localparam logic [31:0] V_W0  [4] = '{32'hB030_0000, 32'hF000_8000,
                                          32'hB025_0000, 32'hB022_0000};

    task automatic run_all();
        logic [31:0] d;
        bit          seen;
        logic [31:0] ba;
        int          w0;

        for (int i = 0; i < 4; i++) begin
            poke(32'h100 + 8*i, 32'h4000 + 32'h800*i);
            poke(32'h104 + 8*i, ((i + 5) << 16) | 32'h800);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!irq && !buf_valid && !mem_req, "R1 outputs", {29'b0, irq, buf_valid, mem_req}, 0);
        rreg(8'h20, d); chk(d == 0, "R1 desc credit", d, 0);
        rreg(8'h34, d); chk(d == 0, "R1 stat credit", d, 0);
        rreg(8'h08, d); chk(d == 0, "R1 istat", d, 0);

        wreg(8'h10, 32'h100); wreg(8'h18, 32'h100); wreg(8'h14, 32);
        wreg(8'h24, 32'h200); wreg(8'h2C, 32'h200); wreg(8'h28, 32);
        wreg(8'h0C, {16'd2044, 16'd2044}); wreg(8'h04, 32'h7); wreg(8'h00, 1);

        // R3 drop with no credit: no memory access
        w0 = wr_count;
        frame(16'd50, 4'b0, seen, ba);
        repeat (10) @(negedge clk);
        chk(!seen && wr_count == w0, "R3 drop no credit", wr_count - w0, 0);

        // R2 enqueue
        wreg(8'h1C, 4); wreg(8'h30, 4);
        rreg(8'h20, d); chk(d == 4, "R2 desc credit", d, 4);
        rreg(8'h34, d); chk(d == 4, "R2 stat credit", d, 4);

        // vector table walk
        for (int i = 0; i < 4; i++) begin
            stall_en = (i == 2);
            frame(V_LEN[i], V_FLG[i], seen, ba);
            stall_en = 1'b0;
            chk(seen && ba == 32'h4000 + 32'h800*i, "R4 buffer address", ba, 32'h4000 + 32'h800*i);
            chk(mem[(32'h200 + 8*i) >> 2] == V_W0[i], "R6 R7 R3 R11 status word0",
                mem[(32'h200 + 8*i) >> 2], V_W0[i]);
            chk(mem[(32'h204 + 8*i) >> 2] == (32'h8000_0000 | ((i + 5) << 16) | V_LEN[i]),
                "R5 status word1", mem[(32'h204 + 8*i) >> 2],
                32'h8000_0000 | ((i + 5) << 16) | V_LEN[i]);
            chk(irq, "R10 irq raised", {31'b0, irq}, 1);
            rreg(8'h08, d); chk(d == 4, "R10 istat", d, 4);
            @(negedge clk); chk(!irq, "R10 cleared on read", {31'b0, irq}, 0);
            if (i == 0) begin
                rreg(8'h18, d); chk(d == 32'h108, "R9 desc advance", d, 32'h108);
            end
        end

        // R9 wrap and credit
        rreg(8'h18, d); chk(d == 32'h100, "R9 desc wrap", d, 32'h100);
        rreg(8'h2C, d); chk(d == 32'h200, "R9 stat wrap", d, 32'h200);
        rreg(8'h20, d); chk(d == 0, "R9 desc credit zero", d, 0);
        rreg(8'h34, d); chk(d == 0, "R9 stat credit zero", d, 0);

        // R2 R3 separate credits: descriptor only is not enough
        poke(32'h200, 32'h0); poke(32'h204, 32'h0);
        wreg(8'h1C, 2);
        w0 = wr_count;
        frame(16'd40, 4'b0, seen, ba);
        repeat (10) @(negedge clk);
        chk(!seen && wr_count == w0, "R3 drop no status credit", wr_count - w0, 0);
        rreg(8'h20, d); chk(d == 2, "R2 desc only credit", d, 2);
        rreg(8'h34, d); chk(d == 0, "R2 stat untouched", d, 0);
        wreg(8'h30, 2);

        // frame A, with a frame offered while busy
        @(negedge clk); fd_valid = 1'b1; fd_len = 16'd80; fd_flags = 4'b0;
        @(negedge clk); fd_len = 16'd33;
        @(negedge clk); fd_valid = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (fd_ready) break;
            @(negedge clk);
        end
        chk(mem[32'h200 >> 2] == 32'hB030_0000, "R3 overrun after drop", mem[32'h200 >> 2], 32'hB030_0000);
        chk(mem[32'h204 >> 2] == 32'h8005_0050, "R5 word1 frame A", mem[32'h204 >> 2], 32'h8005_0050);
        rreg(8'h08, d);

        // frame C: busy drop gives overrun; IEN masks irq
        wreg(8'h04, 0);
        frame(16'd90, 4'b0, seen, ba);
        chk(mem[32'h208 >> 2] == 32'hB030_0000, "R3 overrun after busy drop", mem[32'h208 >> 2], 32'hB030_0000);
        chk(mem[32'h20C >> 2] == 32'h8006_005A, "R5 word1 frame C", mem[32'h20C >> 2], 32'h8006_005A);
        chk(!irq, "R10 masked irq", {31'b0, irq}, 0);
        rreg(8'h08, d); chk(d == 4, "R10 status while masked", d, 4);
        wreg(8'h04, 7);

        // R12 disabled engine ignores frames without overrun
        wreg(8'h1C, 1); wreg(8'h30, 1); wreg(8'h00, 0);
        w0 = wr_count;
        frame(16'd55, 4'b0, seen, ba);
        repeat (10) @(negedge clk);
        chk(!seen && wr_count == w0, "R12 ignored", wr_count - w0, 0);
        wreg(8'h00, 1);
        frame(16'd70, 4'b0, seen, ba);
        chk(seen && ba == 32'h5000, "R12 R4 buffer", ba, 32'h5000);
        chk(mem[32'h210 >> 2] == 32'hF000_0000, "R12 no overrun", mem[32'h210 >> 2], 32'hF000_0000);
        chk(mem[32'h214 >> 2] == 32'h8007_0046, "R5 word1 frame E", mem[32'h214 >> 2], 32'h8007_0046);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        fork
            run_all();
            begin repeat (200000) @(posedge clk); wd = 1'b1; end
        join_any
        disable fork;
        if (wd) begin
            failures++;
            $display("FAIL watchdog expired");
        end
        @(negedge clk);
        checks   += ord_checks;
        failures += ord_fails;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule